// File: doc/BRIEF.md
# DMA External Request Detector

This block watches one channel's external DMA request line and turns accepted requests into transfer commands for a separate transfer engine. The line is first synchronized to the local clock. It can then be sensed by level or by edge, with either polarity. An accepted request raises a command. The engine answers with a one-cycle done strobe for each transfer it finishes. The block counts transfers down from a loaded value and stops the channel when the count is used up.

Two service styles are supported. In cycle-steal style, each accepted request is worth one transfer. In burst style under edge sensing, one edge runs transfers back to back until the count is exhausted. An acknowledge pulse tells the requester that its request was served. From acceptance until that acknowledge, the request line is deliberately not looked at. For level sensing, an overrun option picks when looking resumes:
- Late enough that a requester which drops its line on the acknowledge gets exactly one transfer.
- Early enough that such a requester gets exactly one more.

Top module: `dma_req_detect`

## Requirements
- R1: After a synchronous active-high reset, `xferCmd`, `ackOut` and `doneFlag` are low and `countLeft` is zero.
- R2: `detectSel` codes: 2'b00 low level, 2'b01 falling edge, 2'b10 high level, 2'b11 rising edge. Bit 0 picks edge sensing and bit 1 picks the high/rising sense.
- R3: The request passes a two-stage synchronizer. When the line reaches its active state just before clock edge E0 while the channel waits, `xferCmd` is high after edge E2 and low after edges E0 and E1.
- R4: Under edge sensing, one edge is accepted at most once. A line that stays at its new level causes no further transfer.
- R5: In cycle-steal mode (`burstMode` low), and under level sensing in either mode, each accepted request yields exactly one transfer. After that transfer, `xferCmd` drops.
- R6: In burst mode under edge sensing, one accepted edge keeps `xferCmd` high across successive done strobes until `countLeft` reaches zero.
- R7: `ackOut` is high for exactly one cycle, beginning on the edge that consumes a done strobe for the first transfer of an accepted request. It is never high for the later transfers of a burst, and never without such a done strobe.
- R8: From acceptance until the acknowledge, the request line is ignored. An edge that arrives while the command is still pending produces no transfer.
- R9: With `overrunSel` low, sensing resumes two cycles after the acknowledge cycle (synchronizer depth). A level requester that removes its request on seeing `ackOut` gets exactly one transfer.
- R10: With `overrunSel` high under level sensing, sensing stays live during the acknowledge cycle. Such a requester gets exactly two transfers.
- R11: Each consumed done strobe lowers `countLeft` by one. When it reaches zero, `xferCmd` drops and `doneFlag` rises and stays high while `enable` stays high.
- R12: Raising `enable` with `countLoad` zero sets `doneFlag` after the next edge and never raises `xferCmd`.
- R13: Lowering `enable` aborts the channel. After the next edge, `xferCmd` and `doneFlag` are low, and later requests raise no command until the channel is enabled again.
- R14: A done strobe while `xferCmd` is low changes neither `countLeft` nor `ackOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqIn | input | 1 | External request line (asynchronous) |
| detectSel | input | 2 | Sensing code, see R2 |
| overrunSel | input | 1 | Level-sensing overrun option, see R9/R10 |
| burstMode | input | 1 | 1 = burst, 0 = cycle steal |
| countLoad | input | CNT_W | Transfer count taken when the channel is enabled |
| enable | input | 1 | Channel enable; low aborts |
| xferDone | input | 1 | One-cycle strobe from the transfer engine per finished transfer |
| xferCmd | output | 1 | Transfer command to the engine |
| ackOut | output | 1 | One-cycle acknowledge to the requester |
| countLeft | output | CNT_W | Remaining transfer count |
| doneFlag | output | 1 | Channel finished (count reached zero) |

## Verification
A request is due as a command on the third clock edge after the line changes, and the bench checks the no-command and command cycles exactly at the negative edges in between. The acknowledge is due one edge after the done strobe. A scoreboard queue holds the `countLeft` value expected at each acknowledge and pops it at the negative edge of the acknowledge cycle, which also catches a pulse that is too wide or unexpected. Transfer totals, the completion flag and the absence of commands are checked after a settling window of many cycles, which is longer than any pending engine latency.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2,
    ST_DONE = 2'd3
  } chanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCount;
    logic decCount;
    logic issueAck;
  } ctlStrobes_t;

endpackage

// File: rtl/dma_req_datapath.sv
module dma_req_datapath
  import dma_req_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqIn,
  input  logic [1:0]       detectSel,
  input  logic             overrunSel,
  input  ctlStrobes_t      strobes,
  input  logic [CNT_W-1:0] countLoad,
  output logic             reqHit,
  output logic             sensitive,
  output logic             loadIsZero,
  output logic             countIsOne,
  output logic [CNT_W-1:0] countLeft,
  output logic             ackOut
);

  localparam int HOLD_W = $clog2(SYNC_STAGES + 1);
  localparam logic [HOLD_W-1:0] HOLD_INIT = HOLD_W'(SYNC_STAGES);

  // request synchronizer
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncOut;
  logic                   prevSync;

  always_ff @(posedge clk) begin
    if (rst) syncChain[0] <= 1'b0;
    else     syncChain[0] <= reqIn;
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) syncChain[i] <= 1'b0;
      else     syncChain[i] <= syncChain[i-1];
    end
  end

  assign syncOut = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) prevSync <= 1'b0;
    else     prevSync <= syncOut;
  end

  // detection: bit0 edge select, bit1 active sense
  logic edgeMode;
  logic activeLvl;
  logic levelHit;
  logic edgeHit;

  assign edgeMode  = detectSel[0];
  assign activeLvl = detectSel[1];
  assign levelHit  = (syncOut == activeLvl);
  assign edgeHit   = levelHit && (prevSync != activeLvl);
  assign reqHit    = edgeMode ? edgeHit : levelHit;

  // post-acknowledge holdoff
  logic [HOLD_W-1:0] holdCnt;

  always_ff @(posedge clk) begin
    if (rst)                   holdCnt <= '0;
    else if (strobes.loadCount) holdCnt <= '0;
    else if (strobes.issueAck)  holdCnt <= HOLD_INIT;
    else if (holdCnt != '0)     holdCnt <= holdCnt - 1'b1;
  end

  assign sensitive = (holdCnt == '0) || (!edgeMode && overrunSel);

  // transfer counter
  always_ff @(posedge clk) begin
    if (rst)                    countLeft <= '0;
    else if (strobes.loadCount) countLeft <= countLoad;
    else if (strobes.decCount)  countLeft <= countLeft - 1'b1;
  end

  assign loadIsZero = (countLoad == '0);
  assign countIsOne = (countLeft == CNT_W'(1));

  // acknowledge register
  always_ff @(posedge clk) begin
    if (rst) ackOut <= 1'b0;
    else     ackOut <= strobes.issueAck;
  end

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (rst)
    ackOut |=> !ackOut);

  assert_count_load_R11: assert property (@(posedge clk) disable iff (rst)
    strobes.decCount && (countLeft != '0) |=> countLeft == $past(countLeft) - 1'b1);

endmodule

// File: rtl/dma_req_control.sv
module dma_req_control
  import dma_req_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  logic        xferDone,
  input  logic        burstMode,
  input  logic        edgeMode,
  input  logic        reqHit,
  input  logic        sensitive,
  input  logic        loadIsZero,
  input  logic        countIsOne,
  output ctlStrobes_t strobes,
  output logic        xferCmd,
  output logic        doneFlag,
  output logic        acceptNow
);

  chanState_t state, stateNext;
  logic firstOfReq, firstNext;

  assign acceptNow = (state == ST_WAIT) && enable && reqHit && sensitive;

  always_comb begin
    stateNext = state;
    firstNext = firstOfReq;
    strobes   = '0;
    unique case (state)
      ST_IDLE: begin
        if (enable) begin
          strobes.loadCount = 1'b1;
          stateNext = loadIsZero ? ST_DONE : ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!enable) begin
          stateNext = ST_IDLE;
        end else if (acceptNow) begin
          stateNext = ST_XFER;
          firstNext = 1'b1;
        end
      end
      ST_XFER: begin
        if (!enable) begin
          stateNext = ST_IDLE;
        end else if (xferDone) begin
          strobes.decCount = 1'b1;
          strobes.issueAck = firstOfReq;
          firstNext = 1'b0;
          if (countIsOne)                stateNext = ST_DONE;
          else if (burstMode && edgeMode) stateNext = ST_XFER;
          else                            stateNext = ST_WAIT;
        end
      end
      ST_DONE: begin
        if (!enable) stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      firstOfReq <= 1'b0;
    end else begin
      state      <= stateNext;
      firstOfReq <= firstNext;
    end
  end

  assign xferCmd  = (state == ST_XFER);
  assign doneFlag = (state == ST_DONE);

  assert_abort_R13: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !xferCmd && !doneFlag);

  assert_accept_only_waiting_R8: assert property (@(posedge clk) disable iff (rst)
    xferCmd && !xferDone && enable |=> xferCmd);

endmodule

// File: rtl/dma_req_detect.sv
module dma_req_detect
  import dma_req_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqIn,
  input  logic [1:0]       detectSel,
  input  logic             overrunSel,
  input  logic             burstMode,
  input  logic [CNT_W-1:0] countLoad,
  input  logic             enable,
  input  logic             xferDone,
  output logic             xferCmd,
  output logic             ackOut,
  output logic [CNT_W-1:0] countLeft,
  output logic             doneFlag
);

  ctlStrobes_t strobes;
  logic reqHit, sensitive, loadIsZero, countIsOne, acceptNow;

  dma_req_datapath #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rst        (rst),
    .reqIn      (reqIn),
    .detectSel  (detectSel),
    .overrunSel (overrunSel),
    .strobes    (strobes),
    .countLoad  (countLoad),
    .reqHit     (reqHit),
    .sensitive  (sensitive),
    .loadIsZero (loadIsZero),
    .countIsOne (countIsOne),
    .countLeft  (countLeft),
    .ackOut     (ackOut)
  );

  dma_req_control u_ctl (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .xferDone   (xferDone),
    .burstMode  (burstMode),
    .edgeMode   (detectSel[0]),
    .reqHit     (reqHit),
    .sensitive  (sensitive),
    .loadIsZero (loadIsZero),
    .countIsOne (countIsOne),
    .strobes    (strobes),
    .xferCmd    (xferCmd),
    .doneFlag   (doneFlag),
    .acceptNow  (acceptNow)
  );

  assert_ack_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    ackOut |-> $past(xferDone && xferCmd && enable));

  assert_count_dec_R11: assert property (@(posedge clk) disable iff (rst)
    xferDone && xferCmd && enable |=> countLeft == $past(countLeft) - 1'b1);

  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    doneFlag |-> !xferCmd && countLeft == '0);

  assert_holdoff_R9: assert property (@(posedge clk) disable iff (rst)
    ackOut && !xferCmd && !(overrunSel && !detectSel[0]) |=> !xferCmd);

  assert_stray_done_R14: assert property (@(posedge clk) disable iff (rst)
    xferDone && !xferCmd && !acceptNow && $past(enable) && enable && !$rose(enable)
      |=> $stable(countLeft) && !ackOut);

endmodule

// File: tb/tb_dma_req_detect.sv
module tb_dma_req_detect;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             reqIn = 1'b0;
  logic [1:0]       detectSel = 2'b10;
  logic             overrunSel = 1'b0;
  logic             burstMode = 1'b0;
  logic [CNT_W-1:0] countLoad = '0;
  logic             enable = 1'b0;
  logic             engDone = 1'b0;
  logic             strayDone = 1'b0;
  logic             xferDone;
  logic             xferCmd, ackOut, doneFlag;
  logic [CNT_W-1:0] countLeft;

  assign xferDone = engDone | strayDone;

  dma_req_detect #(.CNT_W(CNT_W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .reqIn(reqIn), .detectSel(detectSel),
    .overrunSel(overrunSel), .burstMode(burstMode), .countLoad(countLoad),
    .enable(enable), .xferDone(xferDone), .xferCmd(xferCmd), .ackOut(ackOut),
    .countLeft(countLeft), .doneFlag(doneFlag)
  );

  always #4 clk = ~clk;  // 125 MHz

  int errors = 0;
  int checks = 0;
  int xfers = 0;
  int engineDelay = 2;
  int engCnt = 0;
  int ackQ[$];
  logic prevAck = 1'b0;

  task automatic checkEq(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask

  // model transfer engine: done strobe engineDelay cycles into a command
  always @(negedge clk) begin
    if (!xferCmd || engDone) begin
      engDone <= 1'b0;
      engCnt  <= 0;
    end else if (engCnt >= engineDelay) begin
      engDone <= 1'b1;
      xfers   <= xfers + 1;
    end else begin
      engCnt <= engCnt + 1;
    end
  end

  // scoreboard monitor for acknowledges
  always @(negedge clk) begin
    if (!rst) begin
      if (ackOut) begin
        if (prevAck) checkEq("R7 ack width cycles>1", 2, 1);
        if (ackQ.size() == 0) checkEq("R7 unexpected ack", 1, 0);
        else checkEq("R7 countLeft at ack", int'(countLeft), ackQ.pop_front());
      end
    end
    prevAck = ackOut;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startChannel(input logic [1:0] sel, input logic ovr,
                              input logic burst, input int cnt);
    @(negedge clk);
    enable = 1'b0;
    detectSel = sel;
    overrunSel = ovr;
    burstMode = burst;
    countLoad = CNT_W'(cnt);
    cycles(4);
    enable = 1'b1;
    xfers = 0;
    cycles(2);
  endtask

  // level requester that removes its request on seeing the acknowledge
  task automatic levelRequest(input logic activeLvl, input string tag);
    int guard = 0;
    @(negedge clk);
    reqIn = activeLvl;
    cycles(2);
    checkEq({tag, " cmd low before 3rd edge"}, int'(xferCmd), 0);
    cycles(1);
    checkEq({tag, " cmd high on 3rd edge"}, int'(xferCmd), 1);
    while (!ackOut && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    reqIn = ~activeLvl;
    cycles(40);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cycles(3);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    checkEq("R1 xferCmd", int'(xferCmd), 0);
    checkEq("R1 ackOut", int'(ackOut), 0);
    checkEq("R1 countLeft", int'(countLeft), 0);
    checkEq("R1 doneFlag", int'(doneFlag), 0);

    // R12 zero count load
    startChannel(2'b10, 1'b0, 1'b0, 0);
    checkEq("R12 doneFlag", int'(doneFlag), 1);
    reqIn = 1'b1;
    cycles(10);
    checkEq("R12 no transfers", xfers, 0);
    checkEq("R12 cmd low", int'(xferCmd), 0);
    reqIn = 1'b0;

    // R9/R3/R2 high level, overrun clear
    startChannel(2'b10, 1'b0, 1'b0, 5);
    ackQ.push_back(4);
    levelRequest(1'b1, "R3");
    checkEq("R9 one transfer high level", xfers, 1);
    checkEq("R11 count after one", int'(countLeft), 4);

    // R10 overrun set: one extra transfer
    startChannel(2'b10, 1'b1, 1'b0, 6);
    ackQ.push_back(5);
    ackQ.push_back(4);
    levelRequest(1'b1, "R10");
    checkEq("R10 two transfers", xfers, 2);
    checkEq("R10 count", int'(countLeft), 4);

    // R2 low level, overrun clear
    reqIn = 1'b1;
    startChannel(2'b00, 1'b0, 1'b0, 3);
    ackQ.push_back(2);
    levelRequest(1'b0, "R2");
    checkEq("R2 low level one transfer", xfers, 1);

    // R5 level with burst still one per request
    reqIn = 1'b0;
    startChannel(2'b10, 1'b0, 1'b1, 4);
    ackQ.push_back(3);
    levelRequest(1'b1, "R5");
    checkEq("R5 level burst one transfer", xfers, 1);
    checkEq("R5 cmd low", int'(xferCmd), 0);

    // R6 rising edge burst to zero
    reqIn = 1'b0;
    startChannel(2'b11, 1'b0, 1'b1, 4);
    ackQ.push_back(3);
    reqIn = 1'b1;
    cycles(3);
    reqIn = 1'b0;
    cycles(40);
    checkEq("R6 burst transfers", xfers, 4);
    checkEq("R11 count zero", int'(countLeft), 0);
    checkEq("R11 doneFlag", int'(doneFlag), 1);
    checkEq("R11 cmd low at end", int'(xferCmd), 0);

    // R4/R5 falling edge cycle steal
    reqIn = 1'b1;
    startChannel(2'b01, 1'b0, 1'b0, 3);
    ackQ.push_back(2);
    reqIn = 1'b0;
    cycles(20);
    checkEq("R5 one edge one transfer", xfers, 1);
    cycles(20);
    checkEq("R4 held level no more", xfers, 1);
    ackQ.push_back(1);
    reqIn = 1'b1;
    cycles(5);
    reqIn = 1'b0;
    cycles(20);
    checkEq("R4 second edge", xfers, 2);
    checkEq("R11 count one left", int'(countLeft), 1);
    checkEq("R11 not done", int'(doneFlag), 0);

    // R8 edges while command pending are ignored
    reqIn = 1'b0;
    engineDelay = 12;
    startChannel(2'b11, 1'b0, 1'b0, 5);
    ackQ.push_back(4);
    reqIn = 1'b1;
    cycles(4);
    reqIn = 1'b0;
    cycles(2);
    reqIn = 1'b1;
    cycles(30);
    checkEq("R8 pending edge ignored", xfers, 1);
    ackQ.push_back(3);
    reqIn = 1'b0;
    cycles(5);
    reqIn = 1'b1;
    cycles(30);
    checkEq("R8 sensing resumes", xfers, 2);
    checkEq("R8 count", int'(countLeft), 3);

    // R14 stray done strobe while waiting
    @(negedge clk);
    strayDone = 1'b1;
    @(negedge clk);
    strayDone = 1'b0;
    cycles(3);
    checkEq("R14 count unchanged", int'(countLeft), 3);
    checkEq("R14 no command", int'(xferCmd), 0);

    // R13 abort
    engineDelay = 50;
    reqIn = 1'b0;
    cycles(5);
    reqIn = 1'b1;
    cycles(3);
    checkEq("R13 cmd before abort", int'(xferCmd), 1);
    cycles(5);
    enable = 1'b0;
    @(negedge clk);
    checkEq("R13 cmd dropped", int'(xferCmd), 0);
    checkEq("R13 doneFlag low", int'(doneFlag), 0);
    reqIn = 1'b0;
    cycles(4);
    reqIn = 1'b1;
    cycles(10);
    checkEq("R13 no command after abort", int'(xferCmd), 0);

    cycles(5);
    checkEq("R7 all acks seen", ackQ.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule